// File: doc/BRIEF.md
# Carry-Select Adder with Increment-Derived Upper Paths

This block adds two unsigned operands and an incoming carry. It returns a result one bit wider than the operands, and the top bit of that result is the final carry. The operand word is cut into groups of rising width: two, two, three, four, five bits and so on. The last group is cut short so that the widths add up exactly to the word size. For example, an 8-bit word gives groups of 2, 2, 3 and 1 bits. A 32-bit word gives 2, 2, 3, 4, 5, 6, 7 and 3 bits.

The lowest group is a single ripple adder that takes the external carry directly. Every higher group first computes its slice with a ripple adder whose carry-in is fixed at zero. A plus-one converter then derives the carry-in-of-one answer from that zero-carry answer, so the group needs no second ripple adder. A two-way select, driven by the real carry from the group below, picks one of the two answers.

The arithmetic is purely combinational. A parameter can place a register on the output, which is cleared by an asynchronous active-low reset. This gives a clean sampling point when the adder sits between clocked stages. No state machine is involved: the only sequential element is that optional output register.

Top module: `csa_adder`

## Requirements
- R1: `result` equals `op_a + op_b + carry_in` computed to WIDTH+1 bits, with the final carry in bit WIDTH.
- R2: For every group above the lowest, the selected group sum and carry equal that slice of `op_a` plus that slice of `op_b` plus the actual carry leaving the group below.
- R3: The plus-one converter of each group gives the zero-carry group result plus one. Its carry output is the zero-carry group carry ORed with the all-ones condition of the zero-carry sum.
- R4: A carry generated at any bit position travels through every following group boundary. For a generate at bit i, with all bits above i set in one operand, the result is exactly 2^WIDTH.
- R5: With REG_OUT=1, `result` presents the sum of the inputs sampled at the previous rising edge of `clk`. While `rst_n` is low, `result` is all zeros whatever the inputs.
- R6: The lowest group uses `carry_in` directly. 0+0+1 gives 1, and all-ones+0+1 gives 2^WIDTH, where only bit WIDTH is set.
- R7: The same source works at WIDTH of 8, 16 and 32, with group widths 2, 2, 3, 4, 5… and the last group cut short to fit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| carry_in | input | 1 | Incoming carry |
| result | output | WIDTH+1 | Sum, with the carry-out in the top bit |

## Verification
The hard case is when a group's all-ones zero-carry sum and a carry arriving from below occur in the same evaluation. The converter's all-ones carry and the select must then both act, and every higher group must flip together. This is forced with all-ones plus zero with `carry_in` set, and with a single generated bit under an all-ones upper field at every bit position. The result is judged against an independent wide-integer sum for the 8-, 16- and 32-bit instances at once. Alternating patterns and seeded random vectors cover the cases where only some groups take their plus-one path.

// File: rtl/csa_pkg.sv
package csa_pkg;

    // Nominal width of group g before truncation: 2, 2, 3, 4, 5, ...
    function automatic int grp_nominal(input int g);
        return (g == 0) ? 2 : g + 1;
    endfunction

    // Bit position where group g starts
    function automatic int grp_lsb(input int g);
        int s;
        s = 0;
        for (int i = 0; i < g; i++) s += grp_nominal(i);
        return s;
    endfunction

    // Number of groups needed to cover n bits
    function automatic int grp_count(input int n);
        int s;
        int g;
        s = 0;
        g = 0;
        while (s < n) begin
            s += grp_nominal(g);
            g++;
        end
        return g;
    endfunction

    // Actual width of group g in an n-bit word (last group truncated)
    function automatic int grp_width(input int n, input int g);
        int l;
        int w;
        l = grp_lsb(g);
        w = grp_nominal(g);
        return (l + w > n) ? n - l : w;
    endfunction

endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic half;
        assign half       = a[i] ^ b[i];
        assign sum[i]     = half ^ chain[i];
        assign chain[i+1] = (a[i] & b[i]) | (chain[i] & half);
    end

    assign cout = chain[W];
endmodule

// File: rtl/csa_inc1.sv
module csa_inc1 #(
    parameter int W = 2
) (
    input  logic [W-1:0] d,
    input  logic         cz,
    output logic [W-1:0] q,
    output logic         cq
);
    // run[i] is high when every bit of d below position i is one
    logic [W:0] run;

    assign run[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign q[i]     = d[i] ^ run[i];
        assign run[i+1] = run[i] & d[i];
    end

    assign cq = cz | run[W];
endmodule

// File: rtl/csa_group.sv
module csa_group #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         csel,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] s_zero;
    logic         c_zero;
    logic [W-1:0] s_one;
    logic         c_one;

    csa_ripple #(.W(W)) u_rca (
        .a    (a),
        .b    (b),
        .cin  (1'b0),
        .sum  (s_zero),
        .cout (c_zero)
    );

    csa_inc1 #(.W(W)) u_inc (
        .d  (s_zero),
        .cz (c_zero),
        .q  (s_one),
        .cq (c_one)
    );

    always_comb begin
        unique case (csel)
            1'b1:    begin sum = s_one;  cout = c_one;  end
            default: begin sum = s_zero; cout = c_zero; end
        endcase
    end

    // Converter output must be the ripple answer plus one, carry included
    assert_inc_plus_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        {c_one, s_one} == ({c_zero, s_zero} + {{W{1'b0}}, 1'b1}));

    // Selected group output must equal the true slice sum with the incoming carry
    assert_group_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        {cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, csel}));
endmodule

// File: rtl/csa_adder.sv
module csa_adder #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH:0]   result
);
    localparam int NGRP = csa_pkg::grp_count(WIDTH);

    logic [NGRP:0]    gcarry;
    logic [WIDTH-1:0] sum_c;
    logic [WIDTH:0]   comb_res;
    logic [WIDTH:0]   ref_sum;

    assign gcarry[0] = carry_in;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LSB = csa_pkg::grp_lsb(g);
        localparam int GW  = csa_pkg::grp_width(WIDTH, g);

        if (g == 0) begin : g_low
            csa_ripple #(.W(GW)) u_low (
                .a    (op_a[LSB +: GW]),
                .b    (op_b[LSB +: GW]),
                .cin  (gcarry[0]),
                .sum  (sum_c[LSB +: GW]),
                .cout (gcarry[1])
            );

            // Lowest group takes the external carry with no select stage
            assert_low_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
                {gcarry[1], sum_c[LSB +: GW]} ==
                ({1'b0, op_a[LSB +: GW]} + {1'b0, op_b[LSB +: GW]} + {{GW{1'b0}}, carry_in}));
        end else begin : g_sel
            csa_group #(.W(GW)) u_grp (
                .clk   (clk),
                .rst_n (rst_n),
                .a     (op_a[LSB +: GW]),
                .b     (op_b[LSB +: GW]),
                .csel  (gcarry[g]),
                .sum   (sum_c[LSB +: GW]),
                .cout  (gcarry[g+1])
            );
        end
    end

    assign comb_res = {gcarry[NGRP], sum_c};
    assign ref_sum  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) result <= '0;
            else        result <= comb_res;
        end

        // Registered output shows the sum of the previous cycle's inputs
        assert_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> result == $past(ref_sum));

        // Output stays cleared while reset is held
        assert_reset_clear_R5: assert property (@(posedge clk)
            !rst_n |-> result == '0);
    end else begin : g_comb
        assign result = comb_res;

        assert_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
            result == ref_sum);
    end
endmodule

// File: tb/csa_adder_tb_top.sv
module csa_adder_tb_top;
    logic        clk;
    logic        rst_n;
    logic [31:0] a;
    logic [31:0] b;
    logic        cin;
    logic [32:0] res32;
    logic [16:0] res16;
    logic [8:0]  res8;

    int n_run;
    int n_fail;

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    csa_adder #(.WIDTH(32), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .op_a(a), .op_b(b), .carry_in(cin), .result(res32));
    csa_adder #(.WIDTH(16), .REG_OUT(1'b1)) dut16_i (
        .clk(clk), .rst_n(rst_n), .op_a(a[15:0]), .op_b(b[15:0]), .carry_in(cin), .result(res16));
    csa_adder #(.WIDTH(8), .REG_OUT(1'b1)) dut8_i (
        .clk(clk), .rst_n(rst_n), .op_a(a[7:0]), .op_b(b[7:0]), .carry_in(cin), .result(res8));

    function automatic logic [63:0] model(input logic [63:0] x, input logic [63:0] y,
                                          input logic c, input int w);
        logic [63:0] m;
        m = (64'd1 << w) - 64'd1;
        return (x & m) + (y & m) + {63'd0, c};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at falling edge, let one rising edge register, sample at next falling edge
    task automatic apply(input string tag, input logic [31:0] x, input logic [31:0] y,
                         input logic c);
        a   = x;
        b   = y;
        cin = c;
        @(posedge clk);
        @(negedge clk);
        chk({tag, " w32"}, {31'd0, res32}, model({32'd0, x}, {32'd0, y}, c, 32));
        chk({tag, " w16"}, {47'd0, res16}, model({32'd0, x}, {32'd0, y}, c, 16));
        chk({tag, " w8"},  {55'd0, res8},  model({32'd0, x}, {32'd0, y}, c, 8));
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        n_run  = 0;
        n_fail = 0;
        rst_n  = 1'b0;
        a      = 32'hFFFF_FFFF;
        b      = 32'h1234_5678;
        cin    = 1'b1;
        repeat (3) @(negedge clk);
        // R5: cleared under reset despite active inputs
        chk("R5 reset w32", {31'd0, res32}, 64'd0);
        chk("R5 reset w8",  {55'd0, res8},  64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R6: external carry enters the lowest group directly
        apply("R6 zero+cin", 32'd0, 32'd0, 1'b1);
        apply("R6 ones+cin", 32'hFFFF_FFFF, 32'd0, 1'b1);
        apply("R1 zeros", 32'd0, 32'd0, 1'b0);
        apply("R1 ones+ones c0", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
        apply("R1 ones+ones c1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        // R3: alternating patterns put some groups on the plus-one path
        apply("R3 alt c0", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
        apply("R3 alt c1", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        apply("R3 alt2 c1", 32'h5555_5555, 32'h5555_5555, 1'b1);
        apply("R3 alt3 c0", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);

        // R4: generate at bit i under an all-ones upper field; R7 across widths
        for (int i = 0; i < 32; i++) begin
            apply("R4 ripple-through", (32'hFFFF_FFFF << i), (32'd1 << i), 1'b0);
        end

        // R5: reset in mid-run clears the output again
        a = 32'hDEAD_BEEF;
        b = 32'h0BAD_F00D;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R5 mid reset w32", {31'd0, res32}, 64'd0);
        chk("R5 mid reset w16", {47'd0, res16}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2/R7: seeded random vectors
        void'($urandom(32'd4242));
        for (int k = 0; k < 400; k++) begin
            logic [31:0] x;
            logic [31:0] y;
            logic        c;
            x = $urandom;
            y = $urandom;
            c = $urandom_range(1, 0) == 1;
            apply("R2 random", x, y, c);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule